// File: doc/BRIEF.md
# Cross-Domain Serial Frame Relay

This block lets a codec port that runs on its own, unlocked bit clock exchange one 32-bit word per frame with a 1 Mbps serial link that is timed from the system clock. The codec port writes its received word onto a holding bus and then flips a toggle line. The relay brings that toggle into the system domain through a synchronizer and takes the word only when it sees the toggle change. It then opens a transfer window and shifts the word out most significant bit first. In the same window it gathers 32 inbound bits from the serial input. The window runs for exactly 32 bit periods, and a bit-period divider restarts at the start of each window.

When the window closes, the gathered word is frozen in a holding register and a return toggle is flipped. A codec-side stage synchronizes that toggle into the codec clock and loads the word onto the codec transmit bus only on a frame sync. If no fresh word has arrived by a frame sync, the previous word is kept and an underrun pulse is raised. If a new codec word arrives while a window is still open, an overrun pulse is raised and the window restarts with the newer word. Because nothing samples one clock domain's data directly from the other, phase drift between the two clocks cannot drop bits.

Top module: `frame_relay_xd`

## Requirements
- R1: While reset is held and in the first cycle after it, ser_out, link_act, bit_stb and lnk_ovr are 0. In the codec domain, cod_tx_word and cod_undr are 0.
- R2: A change of cod_rx_tgl in either direction, with cod_rx_word held steady, makes link_act rise. This happens no sooner than SYNC_STAGES and no later than SYNC_STAGES+2 system clock cycles after the change.
- R3: A window keeps link_act high for exactly 32*CLK_PER_BIT system cycles. bit_stb is high for one cycle at the start of each of the 32 bit periods and is low at every other time.
- R4: Across the window, ser_out carries the captured word most significant bit first, and each bit is held for a whole bit period. ser_out is 0 whenever link_act is 0.
- R5: ser_in is sampled at cycle CLK_PER_BIT/2 of each bit period. The first sample becomes bit 31 of the inbound word.
- R6: A window that has closed at least SYNC_STAGES+2 codec cycles before a cod_fsync pulse sets cod_tx_word to that window's inbound word on the cod_fsync edge. cod_undr stays 0 in that case.
- R7: cod_tx_word changes only on a codec clock edge where cod_fsync is high.
- R8: A cod_fsync with no fresh inbound word keeps cod_tx_word unchanged and pulses cod_undr high for one codec cycle.
- R9: A codec toggle detected during an open window pulses lnk_ovr for one cycle and restarts the window at bit 0 with the newer word. The cut-short window delivers no inbound word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| cod_clk | input | 1 | Codec bit clock |
| cod_rst | input | 1 | Synchronous active-high reset, codec domain |
| cod_rx_word | input | 32 | Word received by the codec port, steady while its toggle crosses |
| cod_rx_tgl | input | 1 | Flips once per new codec word |
| cod_fsync | input | 1 | Codec frame-start pulse, one codec cycle |
| cod_tx_word | output | 32 | Word handed back to the codec port for transmission |
| cod_undr | output | 1 | One-cycle pulse: frame sync arrived without a fresh word |
| ser_in | input | 1 | Inbound serial data |
| ser_out | output | 1 | Outbound serial data, MSB first |
| bit_stb | output | 1 | Marks the first system cycle of each bit period |
| link_act | output | 1 | High while a transfer window is open |
| lnk_ovr | output | 1 | One-cycle pulse: new codec word arrived mid-window |

## Verification
A wrong divider or bit counter shows at the ports within one window. The link_act length would differ from 32 bit periods, bit_stb would land off the period boundary, or ser_out would change inside a period. A broken hand-back path shows at the first frame sync after the window: cod_tx_word would be loaded with the wrong word, loaded without a pending toggle, or fail to load while cod_undr pulses instead. A missed restart on overrun shows at once as an absent lnk_ovr pulse. It also shows within one window, because the newer word fails to appear from bit 0.

// File: rtl/fr_pkg.sv
package fr_pkg;
    localparam int FR_WORD_W = 32;

    typedef logic [FR_WORD_W-1:0] fr_word_t;

    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_XFER = 1'b1
    } fr_phase_e;

    function automatic fr_word_t fr_shift_in(fr_word_t w, logic b);
        return {w[FR_WORD_W-2:0], b};
    endfunction
endpackage

// File: rtl/fr_tgl_sync.sv
module fr_tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fr_link_engine.sv
module fr_link_engine
    import fr_pkg::*;
#(
    parameter int CLK_PER_BIT = 50
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_tgl_s,
    input  fr_word_t rx_word,
    input  logic     ser_in,
    output logic     ser_out,
    output logic     bit_stb,
    output logic     link_act,
    output logic     ovr,
    output fr_word_t in_hold,
    output logic     tx_tgl
);
    localparam int DIV_W = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;
    localparam int CNT_W = $clog2(FR_WORD_W);
    localparam int HALF  = CLK_PER_BIT / 2;

    fr_phase_e        phase;
    logic [DIV_W-1:0] div_cnt;
    logic [CNT_W-1:0] bit_cnt;
    fr_word_t         out_sh, in_sh, in_next;
    logic             tgl_prev;

    wire edge_evt = rx_tgl_s ^ tgl_prev;
    wire per_end  = (div_cnt == DIV_W'(CLK_PER_BIT - 1));
    wire last_bit = (bit_cnt == CNT_W'(FR_WORD_W - 1));

    always_comb begin
        in_next = in_sh;
        if (div_cnt == DIV_W'(HALF)) in_next = fr_shift_in(in_sh, ser_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= FR_IDLE;
            div_cnt  <= '0;
            bit_cnt  <= '0;
            out_sh   <= '0;
            in_sh    <= '0;
            in_hold  <= '0;
            tx_tgl   <= 1'b0;
            tgl_prev <= 1'b0;
            ovr      <= 1'b0;
        end else begin
            tgl_prev <= rx_tgl_s;
            ovr      <= 1'b0;
            if (edge_evt) begin
                ovr     <= (phase == FR_XFER);
                phase   <= FR_XFER;
                div_cnt <= '0;
                bit_cnt <= '0;
                out_sh  <= rx_word;
            end else if (phase == FR_XFER) begin
                in_sh <= in_next;
                if (per_end) begin
                    div_cnt <= '0;
                    out_sh  <= out_sh << 1;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (last_bit) begin
                        phase   <= FR_IDLE;
                        in_hold <= in_next;
                        tx_tgl  <= ~tx_tgl;
                    end
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end

    assign link_act = (phase == FR_XFER);
    assign bit_stb  = link_act && (div_cnt == '0);
    assign ser_out  = link_act && out_sh[FR_WORD_W-1];

    p_window_close_r3: assert property (@(posedge clk) disable iff (rst)
        (link_act && per_end && last_bit && !edge_evt) |=> (!link_act && tx_tgl != $past(tx_tgl)));

    p_bit_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (link_act && !per_end && !edge_evt) |=> $stable(ser_out));

    p_handback_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_tgl != $past(tx_tgl)) |-> ($past(link_act) && $past(per_end) && !link_act));

    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        ovr |-> (link_act && bit_stb && $stable(tx_tgl)));
endmodule

// File: rtl/fr_codec_port.sv
module fr_codec_port
    import fr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tgl_s,
    input  fr_word_t word_in,
    input  logic     fsync,
    output fr_word_t tx_word,
    output logic     undr
);
    logic seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_word <= '0;
            seen    <= 1'b0;
            undr    <= 1'b0;
        end else begin
            undr <= 1'b0;
            if (fsync) begin
                if (tgl_s != seen) begin
                    tx_word <= word_in;
                    seen    <= tgl_s;
                end else begin
                    undr <= 1'b1;
                end
            end
        end
    end

    p_load_on_sync_r7: assert property (@(posedge clk) disable iff (rst)
        !fsync |=> $stable(tx_word));

    p_repeat_r8: assert property (@(posedge clk) disable iff (rst)
        undr |-> ($stable(tx_word) && $past(fsync)));
endmodule

// File: rtl/frame_relay_xd.sv
module frame_relay_xd #(
    parameter int CLK_PER_BIT = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic        sys_clk,
    input  logic        sys_rst,
    input  logic        cod_clk,
    input  logic        cod_rst,
    input  logic [31:0] cod_rx_word,
    input  logic        cod_rx_tgl,
    input  logic        cod_fsync,
    output logic [31:0] cod_tx_word,
    output logic        cod_undr,
    input  logic        ser_in,
    output logic        ser_out,
    output logic        bit_stb,
    output logic        link_act,
    output logic        lnk_ovr
);
    import fr_pkg::*;

    logic     rx_tgl_s, tx_tgl, tx_tgl_s;
    fr_word_t in_hold;

    fr_tgl_sync #(.STAGES(SYNC_STAGES)) u_rx_sync (
        .clk(sys_clk), .rst(sys_rst), .d(cod_rx_tgl), .q(rx_tgl_s)
    );

    fr_link_engine #(.CLK_PER_BIT(CLK_PER_BIT)) u_engine (
        .clk(sys_clk), .rst(sys_rst), .rx_tgl_s(rx_tgl_s), .rx_word(cod_rx_word),
        .ser_in(ser_in), .ser_out(ser_out), .bit_stb(bit_stb), .link_act(link_act),
        .ovr(lnk_ovr), .in_hold(in_hold), .tx_tgl(tx_tgl)
    );

    fr_tgl_sync #(.STAGES(SYNC_STAGES)) u_tx_sync (
        .clk(cod_clk), .rst(cod_rst), .d(tx_tgl), .q(tx_tgl_s)
    );

    fr_codec_port u_codec (
        .clk(cod_clk), .rst(cod_rst), .tgl_s(tx_tgl_s), .word_in(in_hold),
        .fsync(cod_fsync), .tx_word(cod_tx_word), .undr(cod_undr)
    );

    p_idle_reset_r1: assert property (@(posedge sys_clk)
        $past(sys_rst) |-> (!link_act && !ser_out && !lnk_ovr));
endmodule

// File: tb/test_frame_relay_xd.sv
module test_frame_relay_xd;
    localparam int SYS_PER = 10;
    localparam int COD_PER = 14;
    localparam int P       = 8;
    localparam int SYNC    = 2;

    logic        sys_clk = 0, cod_clk = 0;
    logic        sys_rst = 1, cod_rst = 1;
    logic [31:0] cod_rx_word = '0;
    logic        cod_rx_tgl = 0, cod_fsync = 0, ser_in = 0;
    logic [31:0] cod_tx_word;
    logic        cod_undr, ser_out, bit_stb, link_act, lnk_ovr;

    int n_run = 0, n_fail = 0, ovr_cnt = 0;
    bit done = 0;

    always #(SYS_PER/2) sys_clk = ~sys_clk;
    always #(COD_PER/2) cod_clk = ~cod_clk;

    frame_relay_xd #(.CLK_PER_BIT(P), .SYNC_STAGES(SYNC)) i_frame_relay_xd (
        .sys_clk(sys_clk), .sys_rst(sys_rst), .cod_clk(cod_clk), .cod_rst(cod_rst),
        .cod_rx_word(cod_rx_word), .cod_rx_tgl(cod_rx_tgl), .cod_fsync(cod_fsync),
        .cod_tx_word(cod_tx_word), .cod_undr(cod_undr), .ser_in(ser_in),
        .ser_out(ser_out), .bit_stb(bit_stb), .link_act(link_act), .lnk_ovr(lnk_ovr)
    );

    always @(negedge sys_clk) if (!sys_rst && lnk_ovr) ovr_cnt++;

    task automatic chk(string req, bit ok, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_toggle(logic [31:0] w);
        @(negedge cod_clk) cod_rx_word = w;
        @(negedge cod_clk) cod_rx_tgl = ~cod_rx_tgl;
    endtask

    // Called at the negedge of the first cycle of a window.
    task automatic run_window(logic [31:0] ow, logic [31:0] iw);
        logic [31:0] got = '0;
        int bad_stb = 0, bad_act = 0, bad_hold = 0;
        for (int i = 0; i < 32; i++) begin
            for (int j = 0; j < P; j++) begin
                if (j == 0) begin
                    ser_in = iw[31-i];
                    got[31-i] = ser_out;
                end
                if (bit_stb != (j == 0)) bad_stb++;
                if (!link_act) bad_act++;
                if (ser_out != ow[31-i]) bad_hold++;
                @(negedge sys_clk);
            end
        end
        chk("R3 window ends after 32 periods", !link_act && !bit_stb, link_act, 0);
        chk("R3 strobe and window length", bad_stb == 0 && bad_act == 0, bad_stb + bad_act, 0);
        chk("R4 outbound word MSB first", got == ow, got, ow);
        chk("R4 bits held whole period, idle low", bad_hold == 0 && !ser_out, bad_hold, 0);
    endtask

    task automatic fsync_pulse();
        @(negedge cod_clk) cod_fsync = 1;
        @(negedge cod_clk) cod_fsync = 0;
    endtask

    task automatic normal_frame(logic [31:0] ow, logic [31:0] iw);
        int lat = 0;
        logic [31:0] prev;
        int ovr0 = ovr_cnt;
        send_toggle(ow);
        while (!link_act && lat < 20) begin
            @(negedge sys_clk);
            lat++;
        end
        chk("R2 window start latency", lat >= SYNC && lat <= SYNC + 2, lat, SYNC + 2);
        run_window(ow, iw);
        prev = cod_tx_word;
        repeat (SYNC + 3) @(negedge cod_clk);
        chk("R7 word held until frame sync", cod_tx_word == prev, cod_tx_word, prev);
        fsync_pulse();
        chk("R6 inbound word handed back", cod_tx_word == iw, cod_tx_word, iw);
        chk("R6 no underrun on fresh word", !cod_undr, cod_undr, 0);
        chk("R9 no overrun on clean frame", ovr_cnt == ovr0, ovr_cnt, ovr0);
    endtask

    initial begin
        repeat (200000) @(posedge sys_clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] ow, iw, keep;
        int w;
        repeat (4) @(negedge cod_clk);
        @(negedge sys_clk);
        chk("R1 reset outputs", !ser_out && !link_act && !bit_stb && !lnk_ovr,
            {ser_out, link_act, bit_stb, lnk_ovr}, 0);
        sys_rst = 0;
        @(negedge cod_clk) cod_rst = 0;
        @(negedge sys_clk);
        chk("R1 idle after reset", !ser_out && !link_act && !lnk_ovr, link_act, 0);
        chk("R1 codec side reset", cod_tx_word == 0 && !cod_undr, cod_tx_word, 0);

        for (int k = 0; k < 20; k++) begin
            case (k)
                0: ow = 32'h0000_0000;
                1: ow = 32'hFFFF_FFFF;
                2: ow = 32'hAAAA_AAAA;
                3: ow = 32'h8000_0001;
                default: ow = (32'h1 << (k % 32)) ^ (k * 32'h9E37_79B9);
            endcase
            iw = {ow[15:0], ow[31:16]} ^ (32'h5A5A_0F0F + k * 32'h0101_0003);
            normal_frame(ow, iw);
        end

        // R8: frame sync with nothing new
        keep = cod_tx_word;
        fsync_pulse();
        chk("R8 underrun pulse", cod_undr, cod_undr, 1);
        chk("R8 word repeated", cod_tx_word == keep, cod_tx_word, keep);
        @(negedge cod_clk);
        chk("R8 underrun is one cycle", !cod_undr, cod_undr, 0);

        // R9: overrun mid-window
        w = ovr_cnt;
        send_toggle(32'hDEAD_BEEF);
        while (!link_act) @(negedge sys_clk);
        ser_in = 1;
        repeat (10 * P) @(negedge sys_clk);
        send_toggle(32'hC0DE_5A11);
        begin
            int lim = 0;
            while (!lnk_ovr && lim < 20) begin
                @(negedge sys_clk);
                lim++;
            end
        end
        chk("R9 overrun pulse seen", lnk_ovr && bit_stb, lnk_ovr, 1);
        fork
            run_window(32'hC0DE_5A11, 32'h1357_9BDF);
            begin
                repeat (40) @(negedge cod_clk);
                fsync_pulse();
                chk("R9 aborted window gives no word", cod_undr && cod_tx_word == keep,
                    cod_tx_word, keep);
            end
        join
        chk("R9 single overrun pulse", ovr_cnt == w + 1, ovr_cnt, w + 1);
        repeat (SYNC + 3) @(negedge cod_clk);
        fsync_pulse();
        chk("R9 restarted window word handed back", cod_tx_word == 32'h1357_9BDF,
            cod_tx_word, 32'h1357_9BDF);

        // R5: alternating inbound pattern after an odd toggle polarity
        normal_frame(32'h0F0F_F0F0, 32'h5555_AAAA);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule